// File: doc/BRIEF.md
# VME Parallel Configuration Loader

This block lets a VME host push a bitstream into an FPGA that is still blank. It uses the FPGA's byte-wide parallel configuration port. The host sees two write-only locations inside one small address window. A write to the data location carries a 16-bit word. The loader splits that word into two configuration bytes and presents them to the target one after the other, with chip-select and write strobes timed by a small sequencer. A write to the program location pulls the target's program line low for a fixed, stretched interval. The length of the VME strobe does not change that interval. The loader answers each cycle on an open-drain, active-low DTACK. Its output is an enable that pulls the line low, and the line is never driven high.

The target signals success on a dedicated configured pin. Once that pin is seen high, the loader stops driving the configuration pins and stops acknowledging, so the freshly configured FPGA can take over VME handling. The program path stays alive in that state. The target can therefore be sent back into configuration, and the loader takes over again when the configured pin falls. The block runs from the board's 40 MHz clock. The VME system reset acts as its synchronous reset.

Top module: `cfgb_bridge`

## Requirements
- R1: While and just after reset, chip-select and write strobe are high, DTACK and program pulls are inactive, and the configuration pin enable is high.
- R2: A cycle is decoded only when it is a write and address bits [ADDR_W-1:2] equal the same bits of BASE_ADDR. Address bit 1 = 0 selects the data location and bit 1 = 1 selects the program location. Address bit 0 is ignored. Reads and non-matching writes produce no DTACK, no strobe and no program pulse.
- R3: For a data word, bits [15:8] reach the configuration port before bits [7:0].
- R4: Each byte is stable with chip-select low for one clock before the write strobe falls. The strobe stays low for STB_CYCLES clocks. The byte and chip-select are held for one clock after the strobe rises.
- R5: For a data write, DTACK is pulled low only once the second byte has been strobed, exactly 4 + 2*(2+STB_CYCLES) clocks after the data strobe falls. It is released on the third clock edge after the data strobe rises, and the line is only ever pulled low or left floating.
- R6: A write to the program location pulls the program line low for exactly PROG_CYCLES clocks, whether the data strobe is short or held long. DTACK follows 4 clocks after the data strobe falls, with the pulse already running.
- R7: A write that arrives while a program pulse or a byte transfer is running is held. It gets no DTACK and puts no strobe on the port until the earlier work ends and its own transfer completes.
- R8: When the configured input rises, the configuration pin enable falls and DTACK pulling stops by the second clock edge. While the input stays high, data writes are dropped and any transfer in progress is abandoned.
- R9: While configured, a program write still produces the full program pulse. When the configured input falls again, the pin enable returns by the second clock edge and data writes work as before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 40 MHz board clock |
| rst | input | 1 | VME system reset, active high, synchronous |
| vme_as_n | input | 1 | VME address strobe, active low |
| vme_ds_n | input | 1 | VME data strobe, active low |
| vme_write_n | input | 1 | VME write qualifier, low for write |
| vme_addr | input | ADDR_W | VME byte address |
| vme_data | input | 16 | VME write data |
| vme_dtack_pull | output | 1 | High = pad pulls DTACK low, low = pad floats |
| tgt_configured | input | 1 | Target configured flag, externally pulled up |
| cfg_d | output | 8 | Configuration data byte |
| cfg_cs_n | output | 1 | Configuration chip-select, active low |
| cfg_wr_n | output | 1 | Configuration write strobe, active low |
| cfg_oe | output | 1 | Output enable for cfg_d, cfg_cs_n and cfg_wr_n pads |
| tgt_prog_pull | output | 1 | High = pad pulls target program line low |

## Verification
Every result of this block comes from registers, so the bench drives and samples only on falling clock edges and counts those edges. It expects a data DTACK exactly 4 + 2*(2+STB_CYCLES) edges after the data strobe falls, and a program DTACK after 4 edges. DTACK must still be present two edges after the strobe is released and gone at the third. The pin enable must still be high one edge after the configured input moves and low at the second. A monitor samples the port each cycle and derives setup, strobe width, hold and byte order from what it sees. The program pulse length is counted in clocks. Words are swept over walking-one, walking-zero and arithmetic patterns, so the expected byte stream is computed directly from the words written.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;

    localparam int BYTE_W         = 8;
    localparam int WORD_W         = 16;
    localparam int BYTES_PER_WORD = WORD_W / BYTE_W;
    localparam int IDX_W          = (BYTES_PER_WORD > 1) ? $clog2(BYTES_PER_WORD) : 1;

    // Phase of the per-byte write sequencer
    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_SETUP,
        SEQ_STROBE,
        SEQ_HOLD
    } seq_state_e;

    // Kind of host request waiting to be served
    typedef enum logic [1:0] {
        REQ_NONE,
        REQ_DATA,
        REQ_PROG
    } req_kind_e;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              cs_n;
        logic              wr_n;
    } cfg_port_t;

    typedef struct packed {
        req_kind_e         kind;
        logic [WORD_W-1:0] word;
    } host_req_t;

    // Byte number idx of a word, counting from the most significant byte
    function automatic logic [BYTE_W-1:0] pick_byte(input logic [WORD_W-1:0] word,
                                                    input logic [IDX_W-1:0]  idx);
        logic [WORD_W-1:0] shifted;
        shifted = word << (int'(idx) * BYTE_W);
        return shifted[WORD_W-1 -: BYTE_W];
    endfunction

endpackage

// File: rtl/cfgb_sync.sv
module cfgb_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    localparam int CHAIN_W = WIDTH * STAGES;

    logic [CHAIN_W-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain_q <= RST_VAL;
                else     chain_q <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain_q <= {STAGES{RST_VAL}};
                else     chain_q <= {chain_q[CHAIN_W-WIDTH-1:0], d};
            end
        end
    endgenerate

    assign q = chain_q[CHAIN_W-1 -: WIDTH];

endmodule

// File: rtl/cfgb_vme_decode.sv
module cfgb_vme_decode
    import cfgb_pkg::*;
#(
    parameter int              ADDR_W    = 24,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 24'h00A000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                as_n,
    input  logic                ds_n,
    input  logic                write_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [WORD_W-1:0]   data,
    input  logic                drop_data,
    input  logic                accept,
    output logic                cycle_act,
    output host_req_t           req
);

    logic [1:0] strobes_s;
    logic       act_q;
    logic       evt;
    logic       hit;
    logic       unused_addr0;
    host_req_t  req_q;

    cfgb_sync #(
        .WIDTH   (2),
        .STAGES  (2),
        .RST_VAL (2'b11)
    ) u_strobe_sync (
        .clk (clk),
        .rst (rst),
        .d   ({as_n, ds_n}),
        .q   (strobes_s)
    );

    assign cycle_act    = ~strobes_s[1] & ~strobes_s[0];
    assign evt          = cycle_act & ~act_q;
    assign hit          = (addr[ADDR_W-1:2] == BASE_ADDR[ADDR_W-1:2]) & ~write_n;
    assign unused_addr0 = addr[0];

    always_ff @(posedge clk) begin
        if (rst) act_q <= 1'b0;
        else     act_q <= cycle_act;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q.kind <= REQ_NONE;
            req_q.word <= '0;
        end else if (evt && hit) begin
            req_q.kind <= addr[1] ? REQ_PROG : REQ_DATA;
            req_q.word <= data;
        end else if (accept || (drop_data && req_q.kind == REQ_DATA)) begin
            req_q.kind <= REQ_NONE;
        end
    end

    assign req = req_q;

    // A newly decoded write never lands on top of one still waiting
    assert_single_request_R7: assert property (@(posedge clk) disable iff (rst)
        (evt && hit) |-> (req_q.kind == REQ_NONE));

endmodule

// File: rtl/cfgb_byte_seq.sv
module cfgb_byte_seq
    import cfgb_pkg::*;
#(
    parameter int STB_CYCLES = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              kill,
    input  logic [WORD_W-1:0] word,
    output cfg_port_t         port,
    output logic              busy,
    output logic              done
);

    localparam int                STB_W    = $clog2(STB_CYCLES + 1);
    localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(BYTES_PER_WORD - 1);
    localparam logic [STB_W-1:0]  STB_LOAD = STB_W'(STB_CYCLES - 1);

    seq_state_e        state_q;
    logic [IDX_W-1:0]  idx_q;
    logic [STB_W-1:0]  stb_q;
    logic [WORD_W-1:0] word_q;

    always_ff @(posedge clk) begin
        if (rst || kill) begin
            state_q <= SEQ_IDLE;
            idx_q   <= '0;
            stb_q   <= '0;
            if (rst) word_q <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (start) begin
                        word_q  <= word;
                        idx_q   <= '0;
                        state_q <= SEQ_SETUP;
                    end
                end
                SEQ_SETUP: begin
                    stb_q   <= STB_LOAD;
                    state_q <= SEQ_STROBE;
                end
                SEQ_STROBE: begin
                    if (stb_q == '0) state_q <= SEQ_HOLD;
                    else             stb_q   <= stb_q - 1'b1;
                end
                SEQ_HOLD: begin
                    if (idx_q == LAST_IDX) begin
                        state_q <= SEQ_IDLE;
                    end else begin
                        idx_q   <= idx_q + 1'b1;
                        state_q <= SEQ_SETUP;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    always_comb begin
        port.data = (state_q == SEQ_IDLE) ? '0 : pick_byte(word_q, idx_q);
        port.cs_n = (state_q == SEQ_IDLE);
        port.wr_n = (state_q != SEQ_STROBE);
    end

    assign busy = (state_q != SEQ_IDLE);
    assign done = (state_q == SEQ_HOLD) && (idx_q == LAST_IDX);

    // Byte already presented under chip-select in the clock before the strobe
    assert_setup_before_strobe_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(port.wr_n) |-> ($past(!port.cs_n) && $stable(port.data)));

    // Byte and chip-select still present in the clock after the strobe
    assert_hold_after_strobe_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(port.wr_n) |-> (!port.cs_n && $stable(port.data)));

endmodule

// File: rtl/cfgb_prog_stretch.sv
module cfgb_prog_stretch #(
    parameter int PROG_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    output logic active
);

    localparam int                CNT_W    = $clog2(PROG_CYCLES + 1);
    localparam logic [CNT_W-1:0]  CNT_LOAD = CNT_W'(PROG_CYCLES);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)              cnt_q <= '0;
        else if (go && !active) cnt_q <= CNT_LOAD;
        else if (active)      cnt_q <= cnt_q - 1'b1;
    end

    assign active = (cnt_q != '0);

    // Independent length counter for the pulse check
    logic [CNT_W:0] len_q;
    always_ff @(posedge clk) begin
        if (rst || !active) len_q <= '0;
        else                len_q <= len_q + 1'b1;
    end

    assert_pulse_length_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(active) |-> (len_q == (CNT_W+1)'(PROG_CYCLES)));

endmodule

// File: rtl/cfgb_bridge.sv
module cfgb_bridge
    import cfgb_pkg::*;
#(
    parameter int                ADDR_W      = 24,
    parameter logic [ADDR_W-1:0] BASE_ADDR   = 24'h00A000,
    parameter int                STB_CYCLES  = 1,
    parameter int                PROG_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              vme_as_n,
    input  logic              vme_ds_n,
    input  logic              vme_write_n,
    input  logic [ADDR_W-1:0] vme_addr,
    input  logic [15:0]       vme_data,
    output logic              vme_dtack_pull,
    input  logic              tgt_configured,
    output logic [7:0]        cfg_d,
    output logic              cfg_cs_n,
    output logic              cfg_wr_n,
    output logic              cfg_oe,
    output logic              tgt_prog_pull
);

    logic       done_s;
    logic       cycle_act;
    host_req_t  req;
    logic       seq_busy;
    logic       seq_done;
    logic       prog_active;
    logic       data_go;
    logic       prog_go;
    logic       ack_q;
    cfg_port_t  port;

    cfgb_sync #(
        .WIDTH   (1),
        .STAGES  (2),
        .RST_VAL (1'b0)
    ) u_done_sync (
        .clk (clk),
        .rst (rst),
        .d   (tgt_configured),
        .q   (done_s)
    );

    cfgb_vme_decode #(
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_decode (
        .clk       (clk),
        .rst       (rst),
        .as_n      (vme_as_n),
        .ds_n      (vme_ds_n),
        .write_n   (vme_write_n),
        .addr      (vme_addr),
        .data      (vme_data),
        .drop_data (done_s),
        .accept    (data_go | prog_go),
        .cycle_act (cycle_act),
        .req       (req)
    );

    // Work is started only when neither the sequencer nor the pulse is running
    assign data_go = (req.kind == REQ_DATA) && !seq_busy && !prog_active && !done_s;
    assign prog_go = (req.kind == REQ_PROG) && !seq_busy && !prog_active;

    cfgb_byte_seq #(
        .STB_CYCLES (STB_CYCLES)
    ) u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (data_go),
        .kill  (done_s),
        .word  (req.word),
        .port  (port),
        .busy  (seq_busy),
        .done  (seq_done)
    );

    cfgb_prog_stretch #(
        .PROG_CYCLES (PROG_CYCLES)
    ) u_prog (
        .clk    (clk),
        .rst    (rst),
        .go     (prog_go),
        .active (prog_active)
    );

    // Acknowledge latch: set by finished work, cleared when the strobe goes
    always_ff @(posedge clk) begin
        if (rst) ack_q <= 1'b0;
        else     ack_q <= cycle_act & (ack_q | seq_done | prog_go);
    end

    assign vme_dtack_pull = ack_q & ~done_s;
    assign cfg_oe         = ~done_s;
    assign cfg_d          = port.data;
    assign cfg_cs_n       = port.cs_n;
    assign cfg_wr_n       = port.wr_n;
    assign tgt_prog_pull  = prog_active;

    assert_ack_after_work_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(ack_q) |-> $past(seq_done || prog_go));

    assert_no_overlap_R7: assert property (@(posedge clk) disable iff (rst)
        !(seq_busy && prog_active));

    assert_idle_when_configured_R8: assert property (@(posedge clk) disable iff (rst)
        done_s |=> !seq_busy);

endmodule

// File: tb/cfgb_bridge_bench.sv
`timescale 1ns/1ps
module cfgb_bridge_bench;

    localparam int               ADDR_W   = 24;
    localparam logic [23:0]      BASE     = 24'h00A000;
    localparam int               STB      = 2;
    localparam int               PROG     = 16;
    localparam int               LAT_DATA = 4 + 2 * (2 + STB);
    localparam int               LAT_PROG = 4;
    localparam logic [23:0]      A_DATA   = BASE;
    localparam logic [23:0]      A_DATA1  = BASE + 24'd1;
    localparam logic [23:0]      A_PROG   = BASE + 24'd2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        vme_as_n = 1'b1;
    logic        vme_ds_n = 1'b1;
    logic        vme_write_n = 1'b1;
    logic [23:0] vme_addr = '0;
    logic [15:0] vme_data = '0;
    logic        vme_dtack_pull;
    logic        tgt_configured = 1'b0;
    logic [7:0]  cfg_d;
    logic        cfg_cs_n;
    logic        cfg_wr_n;
    logic        cfg_oe;
    logic        tgt_prog_pull;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    cfgb_bridge #(
        .ADDR_W      (ADDR_W),
        .BASE_ADDR   (BASE),
        .STB_CYCLES  (STB),
        .PROG_CYCLES (PROG)
    ) u_cfgb_bridge (
        .clk            (clk),
        .rst            (rst),
        .vme_as_n       (vme_as_n),
        .vme_ds_n       (vme_ds_n),
        .vme_write_n    (vme_write_n),
        .vme_addr       (vme_addr),
        .vme_data       (vme_data),
        .vme_dtack_pull (vme_dtack_pull),
        .tgt_configured (tgt_configured),
        .cfg_d          (cfg_d),
        .cfg_cs_n       (cfg_cs_n),
        .cfg_wr_n       (cfg_wr_n),
        .cfg_oe         (cfg_oe),
        .tgt_prog_pull  (tgt_prog_pull)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Port monitor: captures bytes, checks setup, strobe width and hold
    logic [7:0] cap [512];
    int   cap_n = 0;
    logic prev_wr = 1'b1;
    logic prev_cs = 1'b1;
    logic [7:0] prev_d = '0;
    int   stb_len = 0;
    int   prog_len = 0;
    int   last_prog_len = 0;
    int   prog_pulses = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (prev_wr && !cfg_wr_n) begin
                check(prev_cs == 1'b0 && prev_d == cfg_d, "R4 setup", int'(cfg_d), int'(prev_d));
                check(tgt_prog_pull == 1'b0, "R7 strobe during program", 1, 0);
                if (cap_n < 512) cap[cap_n] = cfg_d;
                cap_n++;
                stb_len = 1;
            end else if (!prev_wr && !cfg_wr_n) begin
                stb_len++;
            end else if (!prev_wr && cfg_wr_n) begin
                check(stb_len == STB, "R4 strobe width", stb_len, STB);
                check(cfg_cs_n == 1'b0 && cfg_d == prev_d, "R4 hold", int'(cfg_d), int'(prev_d));
            end
            if (tgt_prog_pull) prog_len++;
            else if (prog_len != 0) begin
                last_prog_len = prog_len;
                prog_pulses++;
                prog_len = 0;
            end
            prev_wr = cfg_wr_n;
            prev_cs = cfg_cs_n;
            prev_d  = cfg_d;
        end
    end

    task automatic vme_cycle(input logic [23:0] a, input logic [15:0] d, input logic wn,
                             input int hold, input int tmo,
                             output bit acked, output int lat, output int caps_at_ack);
        @(negedge clk);
        vme_addr = a; vme_data = d; vme_write_n = wn; vme_as_n = 1'b0;
        @(negedge clk);
        vme_ds_n = 1'b0;
        lat = 0; acked = 0; caps_at_ack = cap_n;
        while (!acked && lat < tmo) begin
            @(negedge clk);
            lat++;
            if (vme_dtack_pull) begin
                acked = 1;
                caps_at_ack = cap_n;
            end
        end
        repeat (hold) @(negedge clk);
        vme_ds_n = 1'b1; vme_as_n = 1'b1; vme_write_n = 1'b1;
        if (acked) begin
            repeat (2) @(negedge clk);
            check(vme_dtack_pull == 1'b1, "R5 DTACK held two edges after strobe release", int'(vme_dtack_pull), 1);
            @(negedge clk);
            check(vme_dtack_pull == 1'b0, "R5 DTACK released at third edge", int'(vme_dtack_pull), 0);
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic data_word(input logic [23:0] a, input logic [15:0] d);
        bit ok; int lat; int at_ack; int base;
        base = cap_n;
        vme_cycle(a, d, 1'b0, 0, 60, ok, lat, at_ack);
        check(ok, "R5 data write acknowledged", int'(ok), 1);
        check(lat == LAT_DATA, "R5 data acknowledge latency", lat, LAT_DATA);
        check(at_ack - base == 2, "R5 both bytes before DTACK", at_ack - base, 2);
        if (cap_n - base == 2 && base + 1 < 512) begin
            check(cap[base] == d[15:8], "R3 first byte is high byte", int'(cap[base]), int'(d[15:8]));
            check(cap[base+1] == d[7:0], "R3 second byte is low byte", int'(cap[base+1]), int'(d[7:0]));
        end else begin
            check(0, "R3 byte count", cap_n - base, 2);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        compared++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        finish_run();
    end

    initial begin
        bit ok; int lat; int at_ack; int base; int pulses;

        repeat (5) @(negedge clk);
        check(cfg_cs_n && cfg_wr_n && !vme_dtack_pull && !tgt_prog_pull && cfg_oe,
              "R1 state during reset", {cfg_cs_n, cfg_wr_n, vme_dtack_pull, tgt_prog_pull, cfg_oe}, 5'b11001);
        rst = 1'b0;
        @(negedge clk);
        check(cfg_cs_n && cfg_wr_n && !vme_dtack_pull && !tgt_prog_pull && cfg_oe,
              "R1 state after reset", {cfg_cs_n, cfg_wr_n, vme_dtack_pull, tgt_prog_pull, cfg_oe}, 5'b11001);

        // R3 R4 R5: word sweeps
        for (int i = 0; i < 16; i++) data_word(A_DATA, 16'(1) << i);
        for (int i = 0; i < 16; i++) data_word(A_DATA1, ~(16'(1) << i));
        for (int i = 0; i < 8; i++)  data_word(A_DATA, 16'(i * 16'h1357 + 16'h0F0F));
        data_word(A_DATA, 16'h0000);
        data_word(A_DATA, 16'hFFFF);
        data_word(A_DATA1, 16'hA55A);

        // R2: foreign base, read cycles
        base = cap_n; pulses = prog_pulses;
        vme_cycle(BASE + 24'h000100, 16'h1234, 1'b0, 0, 40, ok, lat, at_ack);
        check(!ok && cap_n == base, "R2 foreign address ignored", int'(ok), 0);
        vme_cycle(BASE ^ 24'h800000, 16'h4321, 1'b0, 0, 40, ok, lat, at_ack);
        check(!ok && cap_n == base, "R2 high address bit mismatch ignored", int'(ok), 0);
        vme_cycle(A_DATA, 16'h5678, 1'b1, 0, 40, ok, lat, at_ack);
        check(!ok && cap_n == base, "R2 read of data location ignored", int'(ok), 0);
        vme_cycle(A_PROG, 16'h0000, 1'b1, 0, 40, ok, lat, at_ack);
        check(!ok && prog_pulses == pulses && !tgt_prog_pull, "R2 read of program location ignored",
              prog_pulses - pulses, 0);

        // R6: short strobe
        vme_cycle(A_PROG, 16'h0000, 1'b0, 0, 40, ok, lat, at_ack);
        check(ok && lat == LAT_PROG, "R6 program acknowledge latency", lat, LAT_PROG);
        check(tgt_prog_pull == 1'b1, "R6 pulse running after acknowledge", int'(tgt_prog_pull), 1);
        repeat (PROG + 4) @(negedge clk);
        check(last_prog_len == PROG && prog_pulses == pulses + 1, "R6 pulse length short strobe", last_prog_len, PROG);

        // R6: strobe held well past the pulse
        vme_cycle(A_PROG, 16'h0000, 1'b0, 3 * PROG, 40, ok, lat, at_ack);
        repeat (PROG + 4) @(negedge clk);
        check(ok && last_prog_len == PROG && prog_pulses == pulses + 2, "R6 pulse length long strobe",
              last_prog_len, PROG);

        // R7: data write during a running pulse is held back
        vme_cycle(A_PROG, 16'h0000, 1'b0, 0, 40, ok, lat, at_ack);
        check(tgt_prog_pull == 1'b1, "R7 pulse still running", int'(tgt_prog_pull), 1);
        base = cap_n;
        vme_cycle(A_DATA, 16'hC3E1, 1'b0, 0, 80, ok, lat, at_ack);
        check(ok && lat > LAT_DATA, "R7 stalled acknowledge later than normal", lat, LAT_DATA + 1);
        check(prog_pulses == pulses + 3, "R7 pulse ended before bytes", prog_pulses - pulses, 3);
        check(at_ack - base == 2 && cap[base] == 8'hC3 && cap[base+1] == 8'hE1,
              "R7 stalled word delivered", int'(cap[base]), 8'hC3);

        // R8: configured input hands the bus over
        @(negedge clk);
        tgt_configured = 1'b1;
        @(negedge clk);
        check(cfg_oe == 1'b1, "R8 enable one edge after configured", int'(cfg_oe), 1);
        @(negedge clk);
        check(cfg_oe == 1'b0, "R8 enable off at second edge", int'(cfg_oe), 0);
        base = cap_n;
        vme_cycle(A_DATA, 16'h9ABC, 1'b0, 0, 40, ok, lat, at_ack);
        check(!ok && cap_n == base, "R8 data write dropped while configured", cap_n - base, 0);

        // R9: program path survives
        pulses = prog_pulses;
        vme_cycle(A_PROG, 16'h0000, 1'b0, 0, 40, ok, lat, at_ack);
        check(!ok, "R8 no DTACK while configured", int'(ok), 0);
        repeat (PROG + 4) @(negedge clk);
        check(prog_pulses == pulses + 1 && last_prog_len == PROG, "R9 program pulse while configured",
              last_prog_len, PROG);
        tgt_configured = 1'b0;
        @(negedge clk);
        check(cfg_oe == 1'b0, "R9 still released one edge after drop", int'(cfg_oe), 0);
        @(negedge clk);
        check(cfg_oe == 1'b1, "R9 enable back at second edge", int'(cfg_oe), 1);
        data_word(A_DATA, 16'h7E81);

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule